// File: doc/BRIEF.md
# Byte String Move and Compare Engine

The engine runs one string operation at a time between a source byte string and a destination byte string held in an external byte-wide memory. Each string is described by an origin address and a remaining length. The engine works one byte per step. Every step reads the source byte and the destination byte, computes a result, and advances the descriptors, so the remaining work is always visible at the outputs.

Four operations are available: a single-byte move, a whole-string move that pads with a filler byte, a masked compare, and a bitwise logical combine whose truth table comes from four function bits. An 8-bit mask limits which bit positions take part. A caller can stop an operation between bytes with a halt request. It then restarts the operation from the exposed descriptors, and the final result is the same as a run without the stop.

The memory port expects a synchronous RAM. Data for an address presented in one cycle appears in the next cycle, and a write takes effect at the clock edge that ends the cycle in which the write is presented.

Top module: `strop_engine`

## Requirements
- R1: After a synchronous reset, busy, done, mem_we and ovf are 0 and cmp_res is 2'b00.
- R2: A start pulse in the idle state loads both descriptors and raises busy in the next cycle. Each processed byte adds one to the destination origin and subtracts one from the destination length. It does the same to the source descriptor only while the source length is nonzero. At the end, the descriptor outputs show the remaining work.
- R3: Operation code 0 (single move) processes at most one byte. It writes the source byte, or the filler byte when the source length is 0. With a destination length of 0 it writes nothing and leaves the descriptors unchanged.
- R4: Operation code 1 (string move) writes destination bytes until the destination length reaches 0. It takes source bytes while they remain and the filler byte after that.
- R5: When a string move ends with the destination length 0 and the source length nonzero, ovf becomes 1 if the ovf_en operand was 1, and stays 0 otherwise. The source descriptor shows the unconsumed bytes. Every other ending leaves ovf at 0.
- R6: For operations that write, destination bit positions where the mask bit is 0 keep their old value.
- R7: Operation code 2 (compare) writes no memory. It compares (source AND mask) with (destination AND mask) as unsigned bytes, using the filler when the source is exhausted. It stops at the first unequal pair, with the descriptors still addressing that pair. cmp_res is 2'b00 for equal (destination exhausted), 2'b01 when the source byte is lower, and 2'b10 when it is higher.
- R8: Operation code 3 (logical combine) runs over the destination length. Each masked result bit is func[{s,d}], where s is the source bit (the filler when the source is exhausted) and d is the destination bit.
- R9: A halt input held high makes the operation end before the next byte begins. Restarting the same operation from the output descriptors gives the same memory contents and final descriptors as an uninterrupted run.
- R10: done is high for exactly one cycle per operation, in the cycle after busy falls. All writes of the operation are in memory by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start an operation (idle only) |
| op | input | 2 | Operation code: 0 single move, 1 string move, 2 compare, 3 logical |
| ovf_en | input | 1 | Allow ovf when a string move overruns the destination |
| halt | input | 1 | Stop at the next byte boundary |
| mask | input | 8 | Bit positions that take part |
| fill | input | 8 | Filler byte |
| func | input | 4 | Logical truth table indexed by {s,d} |
| src_org_i | input | ADDR_W | Source origin to load |
| src_len_i | input | LEN_W | Source length to load |
| dst_org_i | input | ADDR_W | Destination origin to load |
| dst_len_i | input | LEN_W | Destination length to load |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| src_org | output | ADDR_W | Current source origin |
| src_len | output | LEN_W | Current source length |
| dst_org | output | ADDR_W | Current destination origin |
| dst_len | output | LEN_W | Current destination length |
| cmp_res | output | 2 | Compare result |
| ovf | output | 1 | Destination overflow flag |

## Verification
The bench builds the engine with ADDR_W=8 and LEN_W=6. With these values a 256-byte memory model covers the full address space, and every byte can be compared after each operation. Lengths up to 63 make exhausting the source, exhausting the destination, overrunning it, and halting part-way through a long move all cheap to reach. Separate source and destination regions, together with seeded random masks, fillers, truth tables and lengths, exercise every operation code. Copying the source into the destination before some compares produces long equal runs and masked-off differences.

// File: rtl/strop_pkg.sv
package strop_pkg;
  typedef enum logic [1:0] {
    OP_MOVE1 = 2'd0,
    OP_MOVES = 2'd1,
    OP_CMP   = 2'd2,
    OP_LOGIC = 2'd3
  } strop_op_t;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LT = 2'd1,
    CMP_GT = 2'd2
  } cmp_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ASRC, S_ADST, S_CAP, S_EXE, S_FIN
  } state_t;
endpackage

// File: rtl/strop_desc.sv
module strop_desc #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] org_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step,
  output logic [ADDR_W-1:0] org,
  output logic [LEN_W-1:0]  len
);
  localparam logic [ADDR_W-1:0] ORG_ONE = ADDR_W'(1);
  localparam logic [LEN_W-1:0]  LEN_ONE = LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      org <= '0;
      len <= '0;
    end else if (load) begin
      org <= org_i;
      len <= len_i;
    end else if (step) begin
      org <= org + ORG_ONE;
      len <= len - LEN_ONE;
    end
  end

  // R2: a step is never taken on an empty descriptor
  assert_step_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
    step |-> (len != '0));

  // R2: a step moves origin up and length down by one
  assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (len == $past(len) - LEN_ONE) && (org == $past(org) + ORG_ONE));

  assert_no_load_step_R2: assert property (@(posedge clk) disable iff (rst)
    !(load && step));
endmodule

// File: rtl/strop_alu.sv
module strop_alu
  import strop_pkg::*;
(
  input  strop_op_t  op,
  input  logic [7:0] mask,
  input  logic [3:0] func,
  input  logic [7:0] s,
  input  logic [7:0] d,
  output logic [7:0] wbyte,
  output logic       neq,
  output logic       src_lt
);
  logic [7:0] f;
  logic [7:0] ms, md;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign f[b] = (op == OP_LOGIC) ? func[{s[b], d[b]}] : s[b];
  end

  assign wbyte  = (d & ~mask) | (f & mask);
  assign ms     = s & mask;
  assign md     = d & mask;
  assign neq    = (ms != md);
  assign src_lt = (ms < md);
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              ovf_en,
  input  logic              halt,
  input  logic [7:0]        mask,
  input  logic [7:0]        fill,
  input  logic [3:0]        func,
  input  logic [ADDR_W-1:0] src_org_i,
  input  logic [LEN_W-1:0]  src_len_i,
  input  logic [ADDR_W-1:0] dst_org_i,
  input  logic [LEN_W-1:0]  dst_len_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_org,
  output logic [LEN_W-1:0]  src_len,
  output logic [ADDR_W-1:0] dst_org,
  output logic [LEN_W-1:0]  dst_len,
  output logic [1:0]        cmp_res,
  output logic              ovf
);
  state_t     state;
  strop_op_t  op_q;
  logic [7:0] mask_q, fill_q, src_q;
  logic [3:0] func_q;
  logic       ovf_en_q, one_done;
  logic       load, step_dst, step_src;
  logic       src_empty, dst_empty;
  logic [7:0] wbyte;
  logic       neq, src_lt;

  assign load      = (state == S_IDLE) && start;
  assign src_empty = (src_len == '0);
  assign dst_empty = (dst_len == '0);
  assign step_dst  = (state == S_EXE) && !((op_q == OP_CMP) && neq);
  assign step_src  = step_dst && !src_empty;

  strop_desc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_src (
    .clk(clk), .rst(rst), .load(load), .org_i(src_org_i), .len_i(src_len_i),
    .step(step_src), .org(src_org), .len(src_len));

  strop_desc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dst (
    .clk(clk), .rst(rst), .load(load), .org_i(dst_org_i), .len_i(dst_len_i),
    .step(step_dst), .org(dst_org), .len(dst_len));

  strop_alu u_alu (
    .op(op_q), .mask(mask_q), .func(func_q), .s(src_q), .d(mem_rdata),
    .wbyte(wbyte), .neq(neq), .src_lt(src_lt));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_MOVE1;
      mask_q    <= '0;
      fill_q    <= '0;
      func_q    <= '0;
      ovf_en_q  <= 1'b0;
      one_done  <= 1'b0;
      src_q     <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cmp_res   <= CMP_EQ;
      ovf       <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q     <= strop_op_t'(op);
          mask_q   <= mask;
          fill_q   <= fill;
          func_q   <= func;
          ovf_en_q <= ovf_en;
          one_done <= 1'b0;
          cmp_res  <= CMP_EQ;
          ovf      <= 1'b0;
          busy     <= 1'b1;
          state    <= S_ASRC;
        end
        S_ASRC: begin
          if (halt || dst_empty || ((op_q == OP_MOVE1) && one_done)) begin
            state <= S_FIN;
          end else begin
            mem_addr <= src_org;
            state    <= S_ADST;
          end
        end
        S_ADST: begin
          mem_addr <= dst_org;
          state    <= S_CAP;
        end
        S_CAP: begin
          src_q <= src_empty ? fill_q : mem_rdata;
          state <= S_EXE;
        end
        S_EXE: begin
          one_done <= 1'b1;
          if (op_q == OP_CMP) begin
            if (neq) begin
              cmp_res <= src_lt ? CMP_LT : CMP_GT;
              state   <= S_FIN;
            end else begin
              state <= S_ASRC;
            end
          end else begin
            mem_we    <= 1'b1;
            mem_addr  <= dst_org;
            mem_wdata <= wbyte;
            state     <= S_ASRC;
          end
        end
        S_FIN: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          ovf   <= (op_q == OP_MOVES) && ovf_en_q && dst_empty && !src_empty;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: compare never writes memory
  assert_no_write_cmp_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op_q != OP_CMP));

  // R6: bits outside the mask keep the destination byte just read
  assert_keep_unmasked_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (((mem_wdata ^ $past(mem_rdata)) & ~mask_q) == 8'h00));

  // R10: done lasts a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: done comes only as busy drops
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy && $past(busy));

  // R5: overflow only ever follows a string move
  assert_ovf_moves_only_R5: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (op_q == OP_MOVES) && !busy);

  // R2: destination length never grows during an operation
  assert_dst_shrinks_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (dst_len <= $past(dst_len)));

  // R3: a single move writes at most once
  assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && op_q == OP_MOVE1) |-> ($past(one_done) == 1'b0) || !$past(busy));
endmodule

// File: tb/strop_engine_test.sv
module strop_engine_test;
  localparam int AW = 8;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          start = 0, ovf_en = 0, halt = 0;
  logic [1:0]    op = 0;
  logic [7:0]    mask = 0, fill = 0;
  logic [3:0]    func = 0;
  logic [AW-1:0] src_org_i = 0, dst_org_i = 0;
  logic [LW-1:0] src_len_i = 0, dst_len_i = 0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          busy, done, ovf;
  logic [AW-1:0] src_org, dst_org;
  logic [LW-1:0] src_len, dst_len;
  logic [1:0]    cmp_res;

  strop_engine #(.ADDR_W(AW), .LEN_W(LW)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .ovf_en(ovf_en), .halt(halt),
    .mask(mask), .fill(fill), .func(func),
    .src_org_i(src_org_i), .src_len_i(src_len_i),
    .dst_org_i(dst_org_i), .dst_len_i(dst_len_i),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .src_org(src_org), .src_len(src_len),
    .dst_org(dst_org), .dst_len(dst_len), .cmp_res(cmp_res), .ovf(ovf));

  // Memory model with a preload port for the bench
  logic [7:0]    ram [0:255];
  logic [7:0]    exp_mem [0:255];
  logic          pk_we = 0;
  logic [AW-1:0] pk_addr = 0;
  logic [7:0]    pk_data = 0;

  always @(posedge clk) begin
    if (pk_we) ram[pk_addr] <= pk_data;
    else if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pk_we = 1; pk_addr = a; pk_data = d;
    @(negedge clk);
    pk_we = 0;
  endtask

  // Reference model of one operation applied to exp_mem
  task automatic model(input int o, input logic [7:0] msk, input logic [7:0] fl, input logic [3:0] fn,
                       input logic oe, inout logic [7:0] so, inout logic [5:0] sl,
                       inout logic [7:0] dor, inout logic [5:0] dl,
                       output logic [1:0] cr, output logic ov);
    logic [7:0] s, d, f;
    int steps;
    cr = 2'b00; ov = 1'b0; steps = 0;
    while (dl != 0 && !(o == 0 && steps == 1)) begin
      s = (sl != 0) ? exp_mem[so] : fl;
      d = exp_mem[dor];
      if (o == 2) begin
        if ((s & msk) != (d & msk)) begin
          cr = ((s & msk) < (d & msk)) ? 2'b01 : 2'b10;
          break;
        end
      end else begin
        for (int b = 0; b < 8; b++) f[b] = (o == 3) ? fn[{s[b], d[b]}] : s[b];
        exp_mem[dor] = (d & ~msk) | (f & msk);
      end
      dor++; dl--;
      if (sl != 0) begin so++; sl--; end
      steps++;
    end
    if (o == 1 && oe && dl == 0 && sl != 0) ov = 1'b1;
  endtask

  task automatic drive(input int o, input logic [7:0] msk, input logic [7:0] fl, input logic [3:0] fn,
                       input logic oe, input logic [7:0] so, input logic [5:0] sl,
                       input logic [7:0] dor, input logic [5:0] dl, input int halt_after);
    @(negedge clk);
    op = o[1:0]; mask = msk; fill = fl; func = fn; ovf_en = oe;
    src_org_i = so; src_len_i = sl; dst_org_i = dor; dst_len_i = dl;
    start = 1;
    @(negedge clk);
    start = 0;
    check("R2", "busy after start", {31'd0, busy}, 32'd1);
    for (int i = 0; !done; i++) begin
      if (halt_after != 0 && i == halt_after) halt = 1;
      @(negedge clk);
    end
    halt = 0;
  endtask

  task automatic run_op(input string req, input int o, input logic [7:0] msk, input logic [7:0] fl,
                        input logic [3:0] fn, input logic oe, input logic [7:0] so, input logic [5:0] sl,
                        input logic [7:0] dor, input logic [5:0] dl);
    logic [7:0] eso, edo;
    logic [5:0] esl, edl;
    logic [1:0] ecr;
    logic       eov;
    int         bad;
    for (int a = 0; a < 256; a++) exp_mem[a] = ram[a];
    eso = so; esl = sl; edo = dor; edl = dl;
    model(o, msk, fl, fn, oe, eso, esl, edo, edl, ecr, eov);
    drive(o, msk, fl, fn, oe, so, sl, dor, dl, 0);
    bad = 0;
    for (int a = 0; a < 256; a++) if (ram[a] !== exp_mem[a]) bad++;
    check(req, "memory bytes wrong", bad, 0);
    check("R2", "src_org", src_org, eso);
    check("R2", "src_len", src_len, esl);
    check("R2", "dst_org", dst_org, edo);
    check("R2", "dst_len", dst_len, edl);
    check("R7", "cmp_res", cmp_res, ecr);
    check("R5", "ovf", ovf, eov);
    @(negedge clk);
    check("R10", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] so, dor, eso, edo, m, fl;
    logic [5:0] sl, dl, esl, edl;
    logic [1:0] ecr;
    logic       eov;
    int         o, bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "mem_we", mem_we, 0);
    check("R1", "cmp_res", cmp_res, 0);
    check("R1", "ovf", ovf, 0);
    for (int a = 0; a < 256; a++) poke(a[7:0], 8'($urandom));

    // R3: single move, normal / empty source / empty destination
    run_op("R3", 0, 8'hFF, 8'h5A, 4'h0, 0, 8'd10, 6'd5, 8'd140, 6'd4);
    run_op("R3", 0, 8'hFF, 8'hA7, 4'h0, 0, 8'd10, 6'd0, 8'd141, 6'd4);
    run_op("R3", 0, 8'hFF, 8'hA7, 4'h0, 0, 8'd10, 6'd3, 8'd142, 6'd0);
    // R4: string move with padding
    run_op("R4", 1, 8'hFF, 8'h20, 4'h0, 1, 8'd20, 6'd3, 8'd150, 6'd9);
    // R5: overrun with and without ovf_en
    run_op("R5", 1, 8'hFF, 8'h20, 4'h0, 1, 8'd30, 6'd12, 8'd170, 6'd5);
    run_op("R5", 1, 8'hFF, 8'h20, 4'h0, 0, 8'd30, 6'd12, 8'd180, 6'd5);
    check("R5", "source remaining", src_len, 7);
    // R6: partial mask move and logic
    run_op("R6", 1, 8'h0F, 8'hEE, 4'h0, 0, 8'd40, 6'd6, 8'd190, 6'd6);
    run_op("R6", 3, 8'hC3, 8'h00, 4'b0110, 0, 8'd40, 6'd6, 8'd200, 6'd6);
    // R8: AND and OR with filler after source ends
    run_op("R8", 3, 8'hFF, 8'h0F, 4'b1000, 0, 8'd50, 6'd3, 8'd210, 6'd7);
    run_op("R8", 3, 8'hFF, 8'h81, 4'b1110, 0, 8'd50, 6'd7, 8'd220, 6'd7);
    // R7: equal strings, then difference at byte 3, then masked-off difference
    for (int i = 0; i < 8; i++) poke(8'(230 + i), ram[60 + i]);
    run_op("R7", 2, 8'hFF, 8'h00, 4'h0, 0, 8'd60, 6'd8, 8'd230, 6'd8);
    check("R7", "equal result", cmp_res, 2'b00);
    poke(8'd233, ram[63] ^ 8'h10);
    run_op("R7", 2, 8'hFF, 8'h00, 4'h0, 0, 8'd60, 6'd8, 8'd230, 6'd8);
    check("R7", "stop on byte 3", dst_len, 5);
    run_op("R7", 2, 8'hEF, 8'h00, 4'h0, 0, 8'd60, 6'd8, 8'd230, 6'd8);
    check("R7", "masked diff ignored", cmp_res, 2'b00);

    // R9: halt part-way, then resume from outputs
    for (int a = 0; a < 256; a++) exp_mem[a] = ram[a];
    eso = 8'd0; esl = 6'd30; edo = 8'd100; edl = 6'd40;
    model(1, 8'hFF, 8'h33, 4'h0, 1, eso, esl, edo, edl, ecr, eov);
    drive(1, 8'hFF, 8'h33, 4'h0, 1, 8'd0, 6'd30, 8'd100, 6'd40, 20);
    check("R9", "halted early", {31'd0, (dst_len != 0 && dst_len < 40)}, 32'd1);
    so = src_org; sl = src_len; dor = dst_org; dl = dst_len;
    drive(1, 8'hFF, 8'h33, 4'h0, 1, so, sl, dor, dl, 0);
    bad = 0;
    for (int a = 0; a < 256; a++) if (ram[a] !== exp_mem[a]) bad++;
    check("R9", "memory after resume", bad, 0);
    check("R9", "dst_org after resume", dst_org, edo);
    check("R9", "src_len after resume", src_len, esl);

    // Random operations
    for (int k = 0; k < 60; k++) begin
      o   = $urandom % 4;
      so  = 8'($urandom % 100);
      dor = 8'(128 + $urandom % 100);
      sl  = 6'($urandom % 20);
      dl  = 6'($urandom % 20);
      m   = ($urandom % 2) ? 8'hFF : 8'($urandom);
      fl  = 8'($urandom);
      if (o == 2 && ($urandom % 2))
        for (int i = 0; i < int'(sl); i++) poke(dor + 8'(i), ram[so + 8'(i)]);
      run_op(o == 0 ? "R3" : o == 1 ? "R4" : o == 2 ? "R7" : "R8",
             o, m, fl, 4'($urandom), 1'($urandom), so, sl, dor, dl);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule